// File: doc/BRIEF.md
# Variable Sample-Rate Register Bank

This block is the part of an audio codec's host register file that governs converter sample rates. It holds an extended-audio control word and two 16-bit rate words. Bit 0 of the control word turns variable-rate operation on. One rate word sets the playback converter rate and the other sets the capture converter rate. The host reaches every word through a single index/data bus. Writes are strobed and take one clock. Read data follows the index combinationally.

Each rate word accepts any value from 7040 Hz (1B80h) to 48000 Hz (BB80h) in 1 Hz steps. A request outside that window is stored as the nearest limit. Each rate word can be reached at a primary index and at a second index that mirrors it. The mirror index is live only while variable-rate operation is on. With variable-rate operation off, both rates stay at 48 kHz. Turning the mode off rewrites both rates to 48 kHz at once.

Top module: `srate_regs`

## Requirements
- R1: A synchronous active-high reset sets the control word to 0000h and both rate words to BB80h.
- R2: Index 2Ah holds the control word. A write stores data bit 0 as the variable-rate enable. A read returns the enable in bit 0, with bits 15:1 always zero.
- R3: With the enable set, a rate write stores 1B80h for any value below 1B80h and BB80h for any value above BB80h. Any value in between is stored unchanged. A read returns the stored value.
- R4: Index 2Ch selects the playback rate and index 32h selects the capture rate. A write to one leaves the other unchanged.
- R5: With the enable set, index 7Ah reads and writes the playback rate and index 78h reads and writes the capture rate, exactly as their primary indexes do.
- R6: With the enable clear, reads of 7Ah and 78h return 0000h. Writes to them change no register.
- R7: A write of 0 to the enable bit sets both rate words to BB80h in the same clock.
- R8: With the enable clear, writes to 2Ch and 32h are ignored, and reads of them return BB80h.
- R9: Reads of any index other than 2Ah, 2Ch, 32h, 78h and 7Ah return 0000h. Writes to those indexes change no register.
- R10: A write with the strobe high is visible on the read data from the next clock edge. The read data changes in the same cycle as the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| idx | input | 7 | Register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `idx` |

## Verification
A wrong internal state shows up on `rdata` as soon as the matching index is put on the bus. No clock is needed, because the read path is combinational. A wrong clamp, a missed forced reset or a leaked mirror write is therefore visible one cycle after the write that caused it. The bench reads all 128 indexes after each phase, so a stray write to an unmapped or disabled index shows up in the sweep that follows it.

// File: rtl/srate_pkg.sv
package srate_pkg;
  localparam int RATE_W    = 16;
  localparam int NUM_RATES = 2;
  localparam logic [RATE_W-1:0] RATE_LO = 16'h1B80;
  localparam logic [RATE_W-1:0] RATE_HI = 16'hBB80;
  localparam int IX_CTRL = 'h2A;

  // index 0: playback, index 1: capture
  function automatic int primary_ix(int n);
    return (n == 0) ? 'h2C : 'h32;
  endfunction

  function automatic int mirror_ix(int n);
    return (n == 0) ? 'h7A : 'h78;
  endfunction

  function automatic logic [RATE_W-1:0] clamp_rate(logic [RATE_W-1:0] v);
    if (v < RATE_LO) return RATE_LO;
    if (v > RATE_HI) return RATE_HI;
    return v;
  endfunction
endpackage

// File: rtl/srate_decode.sv
module srate_decode
  import srate_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 vra,
  output logic                 sel_ctrl,
  output logic [NUM_RATES-1:0] sel_rate_rd,
  output logic [NUM_RATES-1:0] sel_rate_wr
);
  assign sel_ctrl = (idx == IDX_W'(IX_CTRL));

  for (genvar n = 0; n < NUM_RATES; n++) begin : g_dec
    logic hit_pri, hit_mir;
    assign hit_pri = (idx == IDX_W'(primary_ix(n)));
    assign hit_mir = (idx == IDX_W'(mirror_ix(n)));
    assign sel_rate_rd[n] = hit_pri | (hit_mir & vra);
    assign sel_rate_wr[n] = (hit_pri | hit_mir) & vra;
  end
endmodule

// File: rtl/srate_ctrl_reg.sv
module srate_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wbit,
  output logic vra_q,
  output logic clr_evt
);
  assign clr_evt = wr & ~wbit;

  always_ff @(posedge clk) begin
    if (rst)     vra_q <= 1'b0;
    else if (wr) vra_q <= wbit;
  end
endmodule

// File: rtl/srate_rate_reg.sv
module srate_rate_reg
  import srate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              force_def,
  input  logic              wr,
  input  logic [RATE_W-1:0] wdata,
  output logic [RATE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || force_def) q <= RATE_HI;
    else if (wr)          q <= clamp_rate(wdata);
  end
endmodule

// File: rtl/srate_regs.sv
module srate_regs
  import srate_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [RATE_W-1:0] wdata,
  output logic [RATE_W-1:0] rdata
);
  logic                 vra_q;
  logic                 clr_evt;
  logic                 sel_ctrl;
  logic [NUM_RATES-1:0] sel_rate_rd;
  logic [NUM_RATES-1:0] sel_rate_wr;
  logic [RATE_W-1:0]    rate_q [NUM_RATES];
  logic [RATE_W-1:0]    pb_rate, cp_rate;

  srate_decode #(.IDX_W(IDX_W)) u_dec (
    .idx(idx), .vra(vra_q), .sel_ctrl(sel_ctrl),
    .sel_rate_rd(sel_rate_rd), .sel_rate_wr(sel_rate_wr)
  );

  srate_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_en & sel_ctrl), .wbit(wdata[0]),
    .vra_q(vra_q), .clr_evt(clr_evt)
  );

  for (genvar n = 0; n < NUM_RATES; n++) begin : g_rate
    srate_rate_reg u_rate (
      .clk(clk), .rst(rst), .force_def(clr_evt),
      .wr(wr_en & sel_rate_wr[n]), .wdata(wdata), .q(rate_q[n])
    );
  end

  assign pb_rate = rate_q[0];
  assign cp_rate = rate_q[1];

  always_comb begin
    rdata = '0;
    if (sel_ctrl) rdata = {{(RATE_W-1){1'b0}}, vra_q};
    for (int n = 0; n < NUM_RATES; n++)
      if (sel_rate_rd[n]) rdata = rate_q[n];
  end
endmodule

// File: rtl/srate_regs_chk.sv
module srate_regs_chk
  import srate_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  idx,
  input logic [RATE_W-1:0] wdata,
  input logic [RATE_W-1:0] rdata,
  input logic              vra,
  input logic              clr_evt,
  input logic [RATE_W-1:0] pb_rate,
  input logic [RATE_W-1:0] cp_rate
);
  logic mapped;
  assign mapped = (idx == IDX_W'('h2A)) || (idx == IDX_W'('h2C)) || (idx == IDX_W'('h32)) ||
                  (idx == IDX_W'('h78)) || (idx == IDX_W'('h7A));

  a_r1_reset_defaults: assert property (@(posedge clk)
    rst |=> (pb_rate == RATE_HI && cp_rate == RATE_HI && !vra));

  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (idx == IDX_W'('h2A)) |-> (rdata[RATE_W-1:1] == '0));

  a_r3_in_window: assert property (@(posedge clk) disable iff (rst)
    (pb_rate >= RATE_LO && pb_rate <= RATE_HI && cp_rate >= RATE_LO && cp_rate <= RATE_HI));

  a_r3_write_clamped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && vra && idx == IDX_W'('h2C)) |=> (pb_rate == clamp_rate($past(wdata))));

  a_r4_capture_untouched: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'('h2C)) |=> $stable(cp_rate));

  a_r6_mirror_off_zero: assert property (@(posedge clk) disable iff (rst)
    (!vra && (idx == IDX_W'('h7A) || idx == IDX_W'('h78))) |-> (rdata == '0));

  a_r7_clear_forces: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> (pb_rate == RATE_HI && cp_rate == RATE_HI && !vra));

  a_r8_off_at_default: assert property (@(posedge clk) disable iff (rst)
    !vra |-> (pb_rate == RATE_HI && cp_rate == RATE_HI));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (rdata == '0));

  a_r9_unmapped_no_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped) |=> ($stable(pb_rate) && $stable(cp_rate) && $stable(vra)));
endmodule

bind srate_regs srate_regs_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata), .rdata(rdata),
  .vra(vra_q), .clr_evt(clr_evt), .pb_rate(pb_rate), .cp_rate(cp_rate)
);

// File: tb/srate_regs_bench.sv
module srate_regs_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [6:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int tests = 0, fails = 0;
  bit done = 0;
  bit m_en;
  int m_pb, m_cp;

  always #2 clk = ~clk;

  srate_regs u_srate_regs (.clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata), .rdata(rdata));

  function automatic int sat(int v);
    int r;
    r = (v > 48000) ? 48000 : v;
    return (r < 7040) ? 7040 : r;
  endfunction

  function automatic int model_read(int ix);
    case (ix)
      42:  return m_en ? 1 : 0;
      44:  return m_pb;
      50:  return m_cp;
      122: return m_en ? m_pb : 0;
      120: return m_en ? m_cp : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %04h expected %04h", tag, got, exp);
    end
  endtask

  task automatic put(int ix, int d);
    @(negedge clk);
    idx = 7'(ix); wdata = 16'(d); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    case (ix)
      42: begin m_en = d[0]; if (!d[0]) begin m_pb = 48000; m_cp = 48000; end end
      44, 122: if (m_en) m_pb = sat(d);
      50, 120: if (m_en) m_cp = sat(d);
      default: ;
    endcase
  endtask

  task automatic rd(string tag, int ix);
    idx = 7'(ix);
    #0.5;
    check(tag, int'(rdata), model_read(ix));
  endtask

  task automatic sweep(string tag);
    @(negedge clk);
    for (int i = 0; i < 128; i++) rd(tag, i);
  endtask

  initial begin
    m_en = 0; m_pb = 48000; m_cp = 48000;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset defaults
    @(negedge clk);
    rd("R1 ctrl", 42); rd("R1 pb", 44); rd("R1 cp", 50);
    sweep("R9 R6 after reset");
    // R8: writes ignored while disabled
    put(44, 16'h3000); put(50, 16'h2000);
    put(122, 16'h2500); put(120, 16'h2600);
    sweep("R8 R6 disabled writes");
    // R2: only bit 0 kept
    put(42, 16'hFFFF);
    rd("R2 ctrl", 42);
    sweep("R6 R8 enabled, no leak");
    // R3: clamp sweep via primary, R4 independence, R10 next-cycle
    for (int v = 0; v < 65536; v += 257) begin
      put(44, v);
      rd("R3 R10 pb", 44);
      rd("R4 cp kept", 50);
    end
    begin
      int b[8] = '{0, 16'h1B7F, 16'h1B80, 16'h1B81, 16'hBB7F, 16'hBB80, 16'hBB81, 16'hFFFF};
      for (int k = 0; k < 8; k++) begin
        put(50, b[k]); rd("R3 cp bound", 50); rd("R4 pb kept", 44);
        put(120, b[7-k]); rd("R5 cp mirror", 120); rd("R5 cp primary", 50);
        put(122, b[k]); rd("R5 pb mirror", 122); rd("R5 pb primary", 44);
      end
    end
    put(122, 12345); put(120, 9000);
    // R9: unmapped writes
    for (int i = 0; i < 128; i += 5)
      if (i != 42 && i != 44 && i != 50 && i != 120 && i != 122) put(i, 16'h0000);
    sweep("R9 unmapped writes");
    // R7: clearing enable forces defaults
    put(42, 16'hFFFE);
    sweep("R7 cleared");
    put(122, 16'h4000);
    put(42, 1);
    sweep("R6 mirror write while off");
    put(44, 20000); put(50, 30000);
    put(42, 0);
    rd("R7 pb", 44); rd("R7 cp", 50); rd("R2 ctrl", 42);
    // R1: reset mid-run
    put(42, 1); put(44, 8000);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    m_en = 0; m_pb = 48000; m_cp = 48000;
    sweep("R1 re-reset");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule